// File: doc/BRIEF.md
# Ramp-Compare ADC Sequencer with Result Agreement Filter

This block is the digital half of an 8-bit single-slope converter. For each conversion it holds the analog ramp in reset for one cycle, then releases it and counts up from zero, one step per clock. It stops counting when a 1-bit comparator input reports that the ramp has reached the sensed voltage, and the count at that moment becomes the conversion code. A low input gives a short conversion with code 00h. A full-scale input gives the longest conversion, and its code is FFh.

Finished codes pass through an agreement filter before they reach the published output. By default a code is published only when its upper six bits match those of the three conversions before it. Those six bits select a row in downstream lookup tables, so this filter keeps the row from flickering when the input sits near a step. A bypass input turns the filter off, and then every conversion is published. Each publish is marked by a one-cycle strobe. Conversions do not start until an enable qualifier, driven by a supply monitor, is asserted.

Top module: `ramp_adc_filter`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `ramp_rst` is 1, `code_out` is 00h and `pub_stb` is 0.
- R2: While `adc_en` is 0, `ramp_rst` stays 1 and no conversion starts. Raising `adc_en` during a ramp-reset cycle starts the ramp on the next cycle.
- R3: A conversion is one cycle with `ramp_rst` high, followed by ramp cycles with `ramp_rst` low. The internal count is 0 in the first ramp cycle and rises by one each cycle. The code is the count in the first ramp cycle where `cmp_trip` is 1, and the conversion spends code+1 cycles with `ramp_rst` low.
- R4: If `cmp_trip` stays 0 through the ramp cycle where the count is 255, the code is FFh and the conversion spends 256 cycles with `ramp_rst` low.
- R5: When `filt_bypass` is 1 during the ramp-reset cycle that ends a conversion, that conversion's code is published. The match history keeps updating while the filter is bypassed.
- R6: When `filt_bypass` is 0, a code is published only if its bits [7:2] equal those of the three conversions completed just before it. The value published is the full 8-bit code of the newest conversion.
- R7: The match streak counts 1 for the first conversion after reset, and restarts at 1 whenever bits [7:2] differ from the previous conversion's. Once the streak reaches 4 it stays there, so each further matching conversion is also published.
- R8: A publish drives `pub_stb` high for exactly one cycle: the first ramp cycle after the ramp-reset cycle that ends the conversion. `code_out` takes the new value in that same cycle. At all other times `pub_stb` is 0 and `code_out` holds its value.
- R9: Dropping `adc_en` during a ramp abandons the conversion. `ramp_rst` is 1 on the next cycle, nothing is published, and the match history is left as it was.
- R10: `row_sel` always equals `code_out[7:2]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_en | input | 1 | Supply-OK qualifier that enables conversions |
| cmp_trip | input | 1 | Comparator output; high once the ramp has reached the input |
| filt_bypass | input | 1 | 1 publishes every conversion; 0 applies the agreement filter |
| ramp_rst | output | 1 | Holds the analog ramp at zero while high |
| code_out | output | 8 | Last published conversion code |
| row_sel | output | 6 | Lookup-table row, the upper six bits of `code_out` |
| pub_stb | output | 1 | One-cycle pulse when `code_out` is written |

## Verification
The assertions assume that `cmp_trip` can matter only while the ramp is running, and that `filt_bypass` is steady from the start of a conversion until its result is delivered. The bench's comparator model follows both. It gates its trip output with `ramp_rst` and compares a mirrored ramp count against a threshold. The bench changes the threshold and the bypass level only in the first ramp cycle of a conversion. That keeps each trip point exact and places every publish decision in a known cycle. `adc_en` is dropped only in the middle of a ramp and raised again only during a ramp-reset cycle, which matches the start and abort behaviour the checks rely on.

// File: rtl/ssadc_pkg.sv
package ssadc_pkg;

    parameter int CODE_W  = 8;
    parameter int ROW_W   = 6;
    parameter int MATCH_N = 4;

    localparam int STREAK_W = $clog2(MATCH_N + 1);

    typedef logic [CODE_W-1:0]   code_t;
    typedef logic [ROW_W-1:0]    row_t;
    typedef logic [STREAK_W-1:0] streak_t;

    typedef enum logic {
        SEQ_HOLD = 1'b0,
        SEQ_RAMP = 1'b1
    } seq_e;

    typedef struct packed {
        logic  valid;
        code_t code;
    } conv_s;

    function automatic row_t row_of(input code_t c);
        return c[CODE_W-1 -: ROW_W];
    endfunction

endpackage

// File: rtl/ramp_seq.sv
module ramp_seq
    import ssadc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  adc_en,
    input  logic  cmp_trip,
    output logic  ramp_rst,
    output conv_s conv
);

    localparam code_t CNT_TOP = '1;

    seq_e  state;
    code_t ramp_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SEQ_HOLD;
            ramp_cnt <= '0;
            conv     <= '0;
        end else begin
            conv.valid <= 1'b0;
            case (state)
                SEQ_HOLD: begin
                    ramp_cnt <= '0;
                    if (adc_en) state <= SEQ_RAMP;
                end
                SEQ_RAMP: begin
                    if (!adc_en) begin
                        state <= SEQ_HOLD;
                    end else if (cmp_trip || ramp_cnt == CNT_TOP) begin
                        conv.valid <= 1'b1;
                        conv.code  <= ramp_cnt;
                        state      <= SEQ_HOLD;
                    end else begin
                        ramp_cnt <= ramp_cnt + 1'b1;
                    end
                end
                default: state <= SEQ_HOLD;
            endcase
        end
    end

    assign ramp_rst = (state == SEQ_HOLD);

    // R2
    hold_off_chk: assert property (@(posedge clk) disable iff (rst)
        (ramp_rst && !adc_en) |=> ramp_rst);

    // R9
    abort_chk: assert property (@(posedge clk) disable iff (rst)
        (!ramp_rst && !adc_en) |=> (ramp_rst && !conv.valid));

    // R3
    deliver_chk: assert property (@(posedge clk) disable iff (rst)
        conv.valid |-> (ramp_rst && !$past(ramp_rst)));

endmodule

// File: rtl/agree_filter.sv
module agree_filter
    import ssadc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  bypass,
    input  conv_s conv,
    output code_t code_out,
    output logic  pub_stb
);

    localparam streak_t STREAK_FULL = streak_t'(MATCH_N);

    row_t    prev_row;
    logic    have_prev;
    streak_t streak;
    streak_t next_streak;
    logic    same_row;
    logic    publish;

    always_comb begin
        same_row = have_prev && (row_of(conv.code) == prev_row);
        if (!same_row)
            next_streak = streak_t'(1);
        else if (streak == STREAK_FULL)
            next_streak = streak;
        else
            next_streak = streak + 1'b1;
        publish = conv.valid && (bypass || next_streak == STREAK_FULL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_row  <= '0;
            have_prev <= 1'b0;
            streak    <= '0;
            code_out  <= '0;
            pub_stb   <= 1'b0;
        end else begin
            pub_stb <= publish;
            if (publish) code_out <= conv.code;
            if (conv.valid) begin
                prev_row  <= row_of(conv.code);
                have_prev <= 1'b1;
                streak    <= next_streak;
            end
        end
    end

    // R8
    one_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        pub_stb |=> !pub_stb);

    // R8
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pub_stb |-> $stable(code_out));

    // R6
    streak_full_chk: assert property (@(posedge clk) disable iff (rst)
        (pub_stb && !$past(bypass)) |-> (streak == STREAK_FULL));

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (conv.valid && have_prev && row_of(conv.code) != prev_row) |=> (streak == streak_t'(1)));

endmodule

// File: rtl/ramp_adc_filter.sv
module ramp_adc_filter
    import ssadc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              adc_en,
    input  logic              cmp_trip,
    input  logic              filt_bypass,
    output logic              ramp_rst,
    output logic [CODE_W-1:0] code_out,
    output logic [ROW_W-1:0]  row_sel,
    output logic              pub_stb
);

    conv_s conv;
    code_t pub_code;

    ramp_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .adc_en   (adc_en),
        .cmp_trip (cmp_trip),
        .ramp_rst (ramp_rst),
        .conv     (conv)
    );

    agree_filter u_filt (
        .clk      (clk),
        .rst      (rst),
        .bypass   (filt_bypass),
        .conv     (conv),
        .code_out (pub_code),
        .pub_stb  (pub_stb)
    );

    assign code_out = pub_code;
    assign row_sel  = row_of(pub_code);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (ramp_rst && !pub_stb && code_out == '0));

endmodule

// File: tb/ramp_adc_filter_bench.sv
module ramp_adc_filter_bench;
    import ssadc_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       adc_en = 1'b0;
    logic       filt_bypass = 1'b0;
    logic       cmp_trip;
    logic       ramp_rst;
    logic [7:0] code_out;
    logic [5:0] row_sel;
    logic       pub_stb;

    int         thr = 1000;
    logic [8:0] ramp_m = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int         m_prev_row = 0;
    bit         m_have = 0;
    int         m_streak = 0;
    int         m_code = 0;
    bit         pend = 0;
    bit         pend_stb = 0;
    string      pend_tag = "";

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (ramp_rst) ramp_m <= '0;
        else          ramp_m <= ramp_m + 1'b1;
    end

    assign cmp_trip = !ramp_rst && (int'(ramp_m) >= thr);

    ramp_adc_filter u_ramp_adc_filter (
        .clk         (clk),
        .rst         (rst),
        .adc_en      (adc_en),
        .cmp_trip    (cmp_trip),
        .filt_bypass (filt_bypass),
        .ramp_rst    (ramp_rst),
        .code_out    (code_out),
        .row_sel     (row_sel),
        .pub_stb     (pub_stb)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_pending();
        if (pend) begin
            check(pub_stb == pend_stb, {pend_tag, " R8 strobe"}, int'(pub_stb), int'(pend_stb));
            check(int'(code_out) == m_code, {pend_tag, " code"}, int'(code_out), m_code);
            check(int'(row_sel) == (m_code >> 2), "R10 row", int'(row_sel), m_code >> 2);
        end
        pend = 0;
    endtask

    // Entry: at a negedge during a ramp-reset cycle with adc_en high.
    task automatic step(input int v, input bit byp, input string tag);
        int len;
        bit extra;
        int exp_code;
        int row;
        @(negedge clk);
        filt_bypass = byp;
        thr = v;
        check_pending();
        len = 1;
        extra = 0;
        @(negedge clk);
        while (!ramp_rst) begin
            len++;
            if (pub_stb) extra = 1;
            @(negedge clk);
        end
        exp_code = (v > 255) ? 255 : v;
        check(len == exp_code + 1, (v > 255) ? "R4 length" : "R3 length", len, exp_code + 1);
        check(!extra, "R8 stray strobe", int'(extra), 0);
        row = exp_code >> 2;
        if (m_have && row == m_prev_row) begin
            if (m_streak < 4) m_streak++;
        end else begin
            m_streak = 1;
        end
        m_have = 1;
        m_prev_row = row;
        pend_stb = byp || (m_streak == 4);
        if (pend_stb) m_code = exp_code;
        pend = 1;
        pend_tag = tag;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        check(ramp_rst && !pub_stb && code_out == 8'h00, "R1 in reset", int'(code_out), 0);
        rst = 1'b0;
        @(negedge clk);
        check(ramp_rst == 1'b1, "R1 ramp_rst", int'(ramp_rst), 1);
        check(code_out == 8'h00 && pub_stb == 1'b0, "R1 outputs", int'(code_out), 0);
        // R2: no conversion without enable
        repeat (12) @(negedge clk);
        check(ramp_rst == 1'b1, "R2 held", int'(ramp_rst), 1);
        check(pub_stb == 1'b0, "R2 no publish", int'(pub_stb), 0);
        adc_en = 1'b1;

        // R3 R4 R5: full bypass sweep including saturation
        for (int v = 0; v <= 300; v++) step(v, 1'b1, "R3 R5");

        // R6: four codes sharing a row, then a fifth (R7 saturation)
        for (int g = 0; g < 64; g += 9) begin
            for (int k = 0; k < 5; k++) step(g * 4 + (k % 4), 1'b0, "R6");
        end

        // R7: mismatch restarts the streak
        step(40, 1'b0, "R7"); step(41, 1'b0, "R7"); step(42, 1'b0, "R7");
        step(44, 1'b0, "R7"); step(45, 1'b0, "R7"); step(46, 1'b0, "R7");
        step(47, 1'b0, "R7");

        // R7: alternating rows never publish
        for (int k = 0; k < 8; k++) step((k % 2) ? 100 : 120, 1'b0, "R7 alt");

        // R5: history kept while bypassed
        step(200, 1'b1, "R5 hist"); step(201, 1'b1, "R5 hist");
        step(202, 1'b0, "R5 hist"); step(203, 1'b0, "R5 hist");

        // R4 via filter: saturated codes share the top row
        step(252, 1'b0, "R4"); step(300, 1'b0, "R4");
        step(255, 1'b0, "R4"); step(1000, 1'b0, "R4");

        // R9: abort keeps history
        step(80, 1'b0, "R9"); step(81, 1'b0, "R9"); step(82, 1'b0, "R9");
        @(negedge clk);
        thr = 1000;
        check_pending();
        repeat (20) @(negedge clk);
        adc_en = 1'b0;
        @(negedge clk);
        check(ramp_rst == 1'b1, "R9 abort", int'(ramp_rst), 1);
        for (int k = 0; k < 5; k++) begin
            check(pub_stb == 1'b0, "R9 no publish", int'(pub_stb), 0);
            check(int'(code_out) == m_code, "R9 code held", int'(code_out), m_code);
            @(negedge clk);
        end
        adc_en = 1'b1;
        step(83, 1'b0, "R9 resume");
        @(negedge clk);
        check_pending();
        adc_en = 1'b0;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule